// File: doc/BRIEF.md
# Regulator Enable, Soft-Start and Fault-Restart Sequencer

This block is the control core that decides when a step-down regulator may switch, and in what manner. It combines the supply-lockout status, the enable pin and the software enable bit into a single run decision. It then steps the converter through a fixed start-up order: a settling delay, a soft-start ramp with pulse-skipping forced, and a calibration window with fixed-frequency switching forced. During the calibration window it raises power-good. It also sends the register bank to its defaults whenever the supply or the enable pin is absent.

While the converter is switching, the sequencer watches a per-switching-cycle current-limit flag. A sustained overload shuts the converter down for a fixed cool-off time, and then the full start-up order runs again. If the overload is still present within a short window after such a restart, the converter is shut down again quickly, without waiting for a full run of consecutive limit cycles. A hot-die comparator stops the converter at once. A restart waits for a separate cool-die comparator, which gives the cutoff its hysteresis.

All timing counts a one-cycle microsecond tick supplied from outside. A one-cycle strobe marks the end of each switching cycle, and the current-limit flag is sampled on that strobe. The analog comparators are outside this block. All ports are plain level or strobe signals, with no handshake.

Top module: `pwr_seq_top`

## Requirements
- R1: `run_en` is 1 only while `uvlo_ok`, `en_pin` and `en_bit` are all 1 and no thermal or fault shutdown is in force. When any of the three enable inputs drops, `run_en`, `ss_active`, `force_pwm`, `force_pfm` and `pwr_good` are all 0 from the next clock onward.
- R2: `reg_reset` is 1 exactly when `uvlo_ok` or `en_pin` was 0 at the previous clock. It does not depend on `en_bit`, so the register interface stays out of reset with the pin high and the bit low.
- R3: After the sequencer is enabled, `run_en` rises at once and `ss_active` stays 0 until START_DLY_US ticks have been counted. `ss_active` rises within two clocks of the last of these ticks.
- R4: While `ss_active` is 1, `force_pfm` is 1 and `force_pwm` is 0. The ramp has no time limit and ends only when `at_setpoint` is 1. An `at_setpoint` value seen before the ramp starts has no effect.
- R5: When the ramp ends, `force_pwm` is 1 for CAL_US ticks. `pwr_good` rises after PG_DLY_US of those ticks and stays 1 after `force_pwm` falls.
- R6: When OCP_CYCLES consecutive switching strobes each carry `ilim_flag`=1, the converter stops and `pwr_good` clears. It stays off for OFF_US ticks and then repeats the whole sequence of R3 to R5.
- R7: A switching strobe with `ilim_flag`=0 clears the consecutive count. Limit cycles that are interrupted in this way never stop the converter.
- R8: After a restart caused by R6 or by R8 itself, a single `ilim_flag` strobe seen within the first REFAULT_US ticks of switching stops the converter again at the REFAULT_US-th tick. If that window passes with no such strobe, this rule no longer applies until the next fault.
- R9: When `hot_flag` is 1 and the sequencer is enabled, `run_en` is 0 from the next clock. A restart, through the full sequence, waits until `cool_flag` is 1 and `hot_flag` is 0.
- R10: Out of reset, or after `uvlo_ok` is lost, every output is 0 except `reg_reset`, which is 1.
- R11: `force_pwm` and `force_pfm` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply is above the lockout threshold |
| en_pin | input | 1 | Enable pin level |
| en_bit | input | 1 | Software enable bit |
| sw_strobe | input | 1 | One-cycle strobe at the end of each switching cycle |
| ilim_flag | input | 1 | Current limit was hit in this switching cycle (sampled on `sw_strobe`) |
| hot_flag | input | 1 | Die is above the high temperature threshold |
| cool_flag | input | 1 | Die is below the restart temperature threshold |
| at_setpoint | input | 1 | Output has reached its programmed level |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| run_en | output | 1 | Converter may be biased and switching |
| ss_active | output | 1 | Soft-start ramp is in progress |
| force_pwm | output | 1 | Fixed-frequency switching is forced |
| force_pfm | output | 1 | Pulse-skipping is forced |
| pwr_good | output | 1 | Output is declared good |
| reg_reset | output | 1 | Holds the register bank at its defaults |

## Verification
The bench builds the sequencer with START_DLY_US=6, CAL_US=8, PG_DLY_US=3, OFF_US=7, REFAULT_US=4 and OCP_CYCLES=4. With these values, every timed window fits in a few dozen ticks, so the exact tick at each edge can be probed on both sides. With only four consecutive limit cycles needed to trip, the counter reset by a clean cycle can be told apart from a real trip, and a single limit strobe after a restart separates the fast re-trip from the consecutive rule. The two retry outcomes and the thermal hysteresis are each reached in one short run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DELAY = 3'd1,
    ST_RAMP  = 3'd2,
    ST_CAL   = 3'd3,
    ST_RUN   = 3'd4,
    ST_FLT   = 3'd5,
    ST_HOT   = 3'd6
  } seq_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/pwr_seq_timer.sv
// Microsecond interval counter, restarted on every sequencer state change.
module pwr_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          us_tick,
  output logic [TW-1:0] count
);
  localparam logic [TW-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        count <= '0;
    else if (restart)                  count <= '0;
    else if (us_tick && count != CMAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_ocp.sv
// Consecutive current-limit cycle counter.
module pwr_seq_ocp #(
  parameter int OCP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic sw_strobe,
  input  logic ilim_flag,
  output logic trip
);
  localparam int CW = $clog2(OCP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OCP_CYCLES - 1);

  logic [CW-1:0] run_cnt;

  assign trip = active && sw_strobe && ilim_flag && (run_cnt >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run_cnt <= '0;
    else if (!active)           run_cnt <= '0;
    else if (sw_strobe) begin
      if (!ilim_flag)           run_cnt <= '0;
      else if (run_cnt != LAST) run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_retry.sv
// Fast re-trip window that is armed after a fault restart.
module pwr_seq_retry #(
  parameter int REFAULT_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  input  logic active,
  input  logic us_tick,
  input  logic ilim_evt,
  output logic trip
);
  localparam int WW = $clog2(REFAULT_US + 1);
  localparam logic [WW-1:0] WIN = WW'(REFAULT_US);

  logic          armed;
  logic          seen;
  logic [WW-1:0] win_cnt;
  logic          win_done;

  assign win_done = win_cnt >= WIN;
  assign trip     = armed && active && win_done && (seen || ilim_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      seen    <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (disarm)                                  armed <= 1'b0;
      else if (arm)                                armed <= 1'b1;
      else if (armed && active && win_done && !trip) armed <= 1'b0;

      if (!active || !armed) begin
        seen    <= 1'b0;
        win_cnt <= '0;
      end else begin
        if (ilim_evt)                seen    <= 1'b1;
        if (us_tick && !win_done)    win_cnt <= win_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int START_DLY_US = 75,
  parameter int CAL_US       = 85,
  parameter int PG_DLY_US    = 10,
  parameter int OFF_US       = 80,
  parameter int REFAULT_US   = 10,
  parameter int OCP_CYCLES   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_ok,
  input  logic en_pin,
  input  logic en_bit,
  input  logic sw_strobe,
  input  logic ilim_flag,
  input  logic hot_flag,
  input  logic cool_flag,
  input  logic at_setpoint,
  input  logic us_tick,
  output logic run_en,
  output logic ss_active,
  output logic force_pwm,
  output logic force_pfm,
  output logic pwr_good,
  output logic reg_reset
);
  localparam int TMAX = max3(START_DLY_US, CAL_US, OFF_US);
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_START = TW'(START_DLY_US);
  localparam logic [TW-1:0] T_CAL   = TW'(CAL_US);
  localparam logic [TW-1:0] T_PG    = TW'(PG_DLY_US);
  localparam logic [TW-1:0] T_OFF   = TW'(OFF_US);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmr;
  logic          enabled;
  logic          switching;
  logic          ocp_trip;
  logic          rf_trip;
  logic          rst_q;

  assign enabled   = uvlo_ok && en_pin && en_bit;
  assign switching = (st_q == ST_RAMP) || (st_q == ST_CAL) || (st_q == ST_RUN);

  pwr_seq_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st_d != st_q),
    .us_tick (us_tick),
    .count   (tmr)
  );

  pwr_seq_ocp #(.OCP_CYCLES(OCP_CYCLES)) u_ocp (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (switching),
    .sw_strobe (sw_strobe),
    .ilim_flag (ilim_flag),
    .trip      (ocp_trip)
  );

  pwr_seq_retry #(.REFAULT_US(REFAULT_US)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      ((st_q != ST_FLT) && (st_d == ST_FLT)),
    .disarm   (st_q == ST_OFF),
    .active   (switching),
    .us_tick  (us_tick),
    .ilim_evt (sw_strobe && ilim_flag),
    .trip     (rf_trip)
  );

  always_comb begin
    st_d = st_q;
    if (!enabled) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF:  st_d = hot_flag ? ST_HOT : ST_DELAY;
        ST_HOT:  if (cool_flag && !hot_flag) st_d = ST_DELAY;
        ST_FLT: begin
          if (hot_flag)          st_d = ST_HOT;
          else if (tmr >= T_OFF) st_d = ST_DELAY;
        end
        default: begin
          if (hot_flag)                st_d = ST_HOT;
          else if (ocp_trip || rf_trip) st_d = ST_FLT;
          else begin
            case (st_q)
              ST_DELAY: if (tmr >= T_START) st_d = ST_RAMP;
              ST_RAMP:  if (at_setpoint)    st_d = ST_CAL;
              ST_CAL:   if (tmr >= T_CAL)   st_d = ST_RUN;
              default:  st_d = st_q;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      rst_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      rst_q <= !(uvlo_ok && en_pin);
    end
  end

  assign run_en    = (st_q == ST_DELAY) || switching;
  assign ss_active = (st_q == ST_RAMP);
  assign force_pfm = (st_q == ST_RAMP);
  assign force_pwm = (st_q == ST_CAL);
  assign pwr_good  = ((st_q == ST_CAL) && (tmr >= T_PG)) || (st_q == ST_RUN);
  assign reg_reset = rst_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic uvlo_ok,
  input logic en_pin,
  input logic en_bit,
  input logic hot_flag,
  input logic run_en,
  input logic ss_active,
  input logic force_pwm,
  input logic force_pfm,
  input logic pwr_good,
  input logic reg_reset
);
  a_r1_enables_gate_run: assert property (@(posedge clk) disable iff (!rst_n)
    !(uvlo_ok && en_pin && en_bit) |=> !run_en && !pwr_good);

  a_r2_reset_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_ok && en_pin) |=> !reg_reset);

  a_r4_ramp_forces_pfm: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |-> force_pfm && !force_pwm);

  a_r5_good_rises_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> force_pwm);

  a_r9_hot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    hot_flag |=> !run_en);

  a_r10_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> reg_reset && !run_en && !ss_active && !force_pwm && !force_pfm && !pwr_good);

  a_r11_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_pwm && force_pfm));
endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .uvlo_ok   (uvlo_ok),
  .en_pin    (en_pin),
  .en_bit    (en_bit),
  .hot_flag  (hot_flag),
  .run_en    (run_en),
  .ss_active (ss_active),
  .force_pwm (force_pwm),
  .force_pfm (force_pfm),
  .pwr_good  (pwr_good),
  .reg_reset (reg_reset)
);

// File: tb/pwr_seq_top_tb.sv
module pwr_seq_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_ok = 1'b0, en_pin = 1'b0, en_bit = 1'b0;
  logic sw_strobe = 1'b0, ilim_flag = 1'b0;
  logic hot_flag = 1'b0, cool_flag = 1'b0, at_setpoint = 1'b0, us_tick = 1'b0;
  logic run_en, ss_active, force_pwm, force_pfm, pwr_good, reg_reset;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pwr_seq_top #(
    .START_DLY_US(6), .CAL_US(8), .PG_DLY_US(3),
    .OFF_US(7), .REFAULT_US(4), .OCP_CYCLES(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .en_pin(en_pin), .en_bit(en_bit),
    .sw_strobe(sw_strobe), .ilim_flag(ilim_flag), .hot_flag(hot_flag),
    .cool_flag(cool_flag), .at_setpoint(at_setpoint), .us_tick(us_tick),
    .run_en(run_en), .ss_active(ss_active), .force_pwm(force_pwm),
    .force_pfm(force_pfm), .pwr_good(pwr_good), .reg_reset(reg_reset)
  );

  // {uvlo_ok, en_pin, en_bit, expected run_en, expected reg_reset}
  localparam logic [4:0] EN_TABLE [8] = '{
    5'b000_0_1, 5'b001_0_1, 5'b010_0_1, 5'b011_0_1,
    5'b100_0_1, 5'b101_0_1, 5'b110_0_0, 5'b111_1_0
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
      cyc(2);
    end
  endtask

  task automatic strobe(input logic lim);
    @(negedge clk); sw_strobe = 1'b1; ilim_flag = lim;
    @(negedge clk); sw_strobe = 1'b0; ilim_flag = 1'b0;
    cyc(1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R10: reset state
    chk("R10", "run_en", run_en, 1'b0);
    chk("R10", "ss_active", ss_active, 1'b0);
    chk("R10", "pwr_good", pwr_good, 1'b0);
    chk("R10", "force_pwm", force_pwm, 1'b0);
    chk("R10", "reg_reset", reg_reset, 1'b1);
    rst_n = 1'b1;
    cyc(2);

    // R1 / R2: enable combinations
    for (int v = 0; v < 8; v++) begin
      {uvlo_ok, en_pin, en_bit} = EN_TABLE[v][4:2];
      cyc(3);
      chk("R1", $sformatf("run_en vec %0d", v), run_en, EN_TABLE[v][1]);
      chk("R2", $sformatf("reg_reset vec %0d", v), reg_reset, EN_TABLE[v][0]);
    end
    {uvlo_ok, en_pin, en_bit} = 3'b000;
    cyc(2);

    // R3: start delay
    {uvlo_ok, en_pin, en_bit} = 3'b111;
    cyc(2);
    chk("R3", "run_en at enable", run_en, 1'b1);
    chk("R3", "ss before delay", ss_active, 1'b0);
    ticks(5);
    chk("R3", "ss after 5 ticks", ss_active, 1'b0);
    ticks(1);
    chk("R3", "ss after 6 ticks", ss_active, 1'b1);
    // R4: ramp forces pulse skipping, untimed
    chk("R4", "force_pfm in ramp", force_pfm, 1'b1);
    chk("R4", "force_pwm in ramp", force_pwm, 1'b0);
    ticks(20);
    chk("R4", "ramp waits for setpoint", ss_active, 1'b1);
    chk("R11", "modes exclusive", force_pwm & force_pfm, 1'b0);

    // R5: calibration window and power-good
    at_setpoint = 1'b1;
    cyc(2);
    at_setpoint = 1'b0;
    chk("R5", "ss ends", ss_active, 1'b0);
    chk("R5", "force_pwm in cal", force_pwm, 1'b1);
    chk("R5", "force_pfm in cal", force_pfm, 1'b0);
    ticks(2);
    chk("R5", "pg before delay", pwr_good, 1'b0);
    ticks(1);
    chk("R5", "pg after delay", pwr_good, 1'b1);
    ticks(4);
    chk("R5", "pwm still forced", force_pwm, 1'b1);
    ticks(1);
    chk("R5", "pwm released", force_pwm, 1'b0);
    chk("R5", "pg holds in run", pwr_good, 1'b1);

    // R7: interrupted limit run does not trip
    for (int i = 0; i < 3; i++) strobe(1'b1);
    strobe(1'b0);
    for (int i = 0; i < 3; i++) strobe(1'b1);
    chk("R7", "run after broken run", run_en, 1'b1);
    // R6: consecutive trip, off time, full restart
    strobe(1'b1);
    chk("R6", "run_en after trip", run_en, 1'b0);
    chk("R6", "pg after trip", pwr_good, 1'b0);
    ticks(6);
    chk("R6", "still off", run_en, 1'b0);
    ticks(1);
    chk("R6", "restart", run_en, 1'b1);
    chk("R6", "delay before ramp", ss_active, 1'b0);
    ticks(6);
    chk("R6", "ramp after restart", ss_active, 1'b1);

    // R8: single limit strobe after restart re-trips at window end
    strobe(1'b1);
    ticks(3);
    chk("R8", "within window", run_en, 1'b1);
    ticks(1);
    chk("R8", "retrip at window end", run_en, 1'b0);
    ticks(7);
    chk("R8", "second restart", run_en, 1'b1);
    ticks(6);
    chk("R8", "ramp again", ss_active, 1'b1);
    ticks(4);
    chk("R8", "clean window keeps run", run_en, 1'b1);
    strobe(1'b1);
    ticks(5);
    chk("R8", "disarmed after clean window", run_en, 1'b1);

    // R9: thermal cutoff with hysteresis
    hot_flag = 1'b1;
    cyc(2);
    chk("R9", "hot stops", run_en, 1'b0);
    chk("R9", "hot clears ramp", ss_active, 1'b0);
    hot_flag = 1'b0;
    cyc(3);
    chk("R9", "waits for cool", run_en, 1'b0);
    cool_flag = 1'b1;
    cyc(2);
    cool_flag = 1'b0;
    chk("R9", "restarts on cool", run_en, 1'b1);
    chk("R9", "restart via delay", ss_active, 1'b0);

    // R1 / R2: bit drop during calibration
    ticks(6);
    at_setpoint = 1'b1;
    cyc(2);
    at_setpoint = 1'b0;
    ticks(3);
    chk("R5", "pg in cal", pwr_good, 1'b1);
    en_bit = 1'b0;
    cyc(2);
    chk("R1", "bit drop clears pg", pwr_good, 1'b0);
    chk("R1", "bit drop stops run", run_en, 1'b0);
    chk("R2", "regs live with bit low", reg_reset, 1'b0);
    en_bit = 1'b1;
    cyc(2);
    chk("R1", "bit return restarts", run_en, 1'b1);

    // R10: supply loss
    uvlo_ok = 1'b0;
    cyc(2);
    chk("R10", "uvlo run_en", run_en, 1'b0);
    chk("R10", "uvlo reg_reset", reg_reset, 1'b1);
    chk("R10", "uvlo force_pfm", force_pfm, 1'b0);
    chk("R10", "uvlo pg", pwr_good, 1'b0);

    finish_run();
  end
endmodule